// File: doc/BRIEF.md
# Indirect Table Access Port

This block lets software reach several small internal lookup tables through two registers: an address register and a data port. The address register names a table, an entry index within it, and whether the index should step forward after each data access. A read of the data port returns the addressed entry in the same cycle. A write to the data port stores into that entry. Either kind of data access can then advance the index, which wraps at the size of the selected table.

Four tables have storage: an interrupt-vector table, a window table, a translation-validation table with two entries per partitionable endpoint (PE), and a PE-event table. One further select code is a stub. It has a depth but no storage, reads as zero and raises no error. Every other select code is invalid.

Writes to the interrupt-vector table are cleaned so that only three fields survive. These writes also announce the entry on a strobe that carries the target server and the priority. Writes to the window table raise a strobe that carries the entry index, so a consumer outside the block can re-evaluate that window.

Top module: `tap_port`

## Requirements
- R1: After reset, the address register reads zero, every stored table entry reads zero, and both event strobes are low.
- R2: A write to the address register keeps only three fields: the index in bits [7:0], the table select in bits [19:16] and the auto-step flag in bit 31. A read of the address register returns those fields in the same cycle, with every other bit zero.
- R3: `acc_rdata` is zero in any cycle without a read (no access, or a write). A data read returns the addressed entry combinationally, in the same cycle.
- R4: Data writes to the window, translation-validation and PE-event tables store all 64 bits. The new value is readable from the next cycle.
- R5: A data access to a valid select with the auto-step flag set changes the index in the next cycle to (index + 1) masked by the table's depth minus one, which clears the higher index bits. With the flag clear, the index is unchanged.
- R6: The table select codes are 0 for the interrupt-vector table (8 entries), 1 for the window table (16 entries), 2 for translation validation (8 entries) and 3 for PE event (4 entries). The entry used is the index modulo the depth. Select 4 is a 32-deep stub: it reads zero, ignores writes, flags no error and still steps its index.
- R7: A data access with a select of 5 to 15 drives `tbl_err` high in that cycle and reads zero. It writes nothing and leaves the index unchanged.
- R8: An interrupt-vector write keeps only three fields: server in bits [39:24], priority in bits [15:8] and node in bits [51:48]. All other bits are stored as zero.
- R9: In the cycle after an interrupt-vector write, `ivt_evt_valid` is high for one cycle. It carries the entry index, the server field shifted right by two, and the priority.
- R10: In the cycle after a window-table write, `win_evt_valid` is high for one cycle and carries the entry index. Other writes and all reads raise no window strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| acc_valid | input | 1 | Access in this cycle |
| acc_write | input | 1 | 1 = write, 0 = read |
| acc_is_data | input | 1 | 1 = data port, 0 = address register |
| acc_wdata | input | 64 | Write value |
| acc_rdata | output | 64 | Read value, same cycle |
| tbl_err | output | 1 | Data access to an invalid select |
| win_evt_valid | output | 1 | Window entry was written |
| win_evt_index | output | 4 | Index of the written window entry |
| ivt_evt_valid | output | 1 | Interrupt-vector entry was written |
| ivt_evt_index | output | 3 | Index of the written interrupt-vector entry |
| ivt_evt_server | output | 14 | Server field shifted right by two |
| ivt_evt_prio | output | 8 | Priority field |

## Verification
A wrong index register shows up in the very next data read: the read returns another entry's value, or the address register read-back disagrees with the stepped and wrapped value. A wrong entry write or a wrong sanitise mask stays hidden until that entry is read back. For that reason the bench reads back every entry of every table. A misrouted side effect shows up one cycle after the write, as a strobe that is missing, extra or carries the wrong fields.

// File: rtl/tap_pkg.sv
package tap_pkg;
   localparam int DW       = 64;
   localparam int SEL_W    = 4;
   localparam int SEL_LSB  = 16;
   localparam int AINC_BIT = 31;

   localparam logic [SEL_W-1:0] T_IVT  = 4'd0;
   localparam logic [SEL_W-1:0] T_WIN  = 4'd1;
   localparam logic [SEL_W-1:0] T_TVT  = 4'd2;
   localparam logic [SEL_W-1:0] T_PEV  = 4'd3;
   localparam logic [SEL_W-1:0] T_STUB = 4'd4;
   localparam int NUM_STORED = 4;

   localparam int SRV_LSB  = 24;
   localparam int SRV_W    = 16;
   localparam int PRI_LSB  = 8;
   localparam int PRI_W    = 8;
   localparam int NODE_LSB = 48;
   localparam int NODE_W   = 4;

   function automatic logic [DW-1:0] field_mask(int lsb, int w);
      logic [DW-1:0] m;
      m = '0;
      for (int i = 0; i < w; i++) m[lsb+i] = 1'b1;
      return m;
   endfunction

   localparam logic [DW-1:0] IVT_KEEP = field_mask(SRV_LSB, SRV_W)
                                      | field_mask(PRI_LSB, PRI_W)
                                      | field_mask(NODE_LSB, NODE_W);

   function automatic bit is_pow2(int v);
      return (v > 1) && ((v & (v - 1)) == 0);
   endfunction
endpackage

// File: rtl/tap_table_ram.sv
module tap_table_ram
   import tap_pkg::*;
#(
   parameter int             DEPTH = 16,
   parameter logic [DW-1:0]  KEEP  = '1
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     we,
   input  logic [$clog2(DEPTH)-1:0] idx,
   input  logic [DW-1:0]            wdata,
   output logic [DW-1:0]            rdata
);
   logic [DW-1:0] mem [DEPTH];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
      end else if (we) begin
         mem[idx] <= wdata & KEEP;
      end
   end

   assign rdata = mem[idx];
endmodule

// File: rtl/tap_addr_ctl.sv
module tap_addr_ctl
   import tap_pkg::*;
#(
   parameter int IDX_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_addr,
   input  logic [DW-1:0]    wdata,
   input  logic             data_acc,
   input  logic             tbl_ok,
   input  logic [IDX_W-1:0] mask,
   output logic [IDX_W-1:0] idx,
   output logic [SEL_W-1:0] sel,
   output logic             ainc,
   output logic [DW-1:0]    addr_word
);
   logic step;
   assign step = data_acc & tbl_ok & ainc;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         idx  <= '0;
         sel  <= '0;
         ainc <= 1'b0;
      end else if (wr_addr) begin
         idx  <= wdata[IDX_W-1:0];
         sel  <= wdata[SEL_LSB +: SEL_W];
         ainc <= wdata[AINC_BIT];
      end else if (step) begin
         idx  <= (idx + 1'b1) & mask;
      end
   end

   always_comb begin
      addr_word                   = '0;
      addr_word[IDX_W-1:0]        = idx;
      addr_word[SEL_LSB +: SEL_W] = sel;
      addr_word[AINC_BIT]         = ainc;
   end

   // R5: a stepped index never keeps bits above the table's mask
   p_step_wrap_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (step && !wr_addr) |=> ((idx & ~$past(mask)) == '0));

   // R5: with no step and no address write, the index holds
   p_idx_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (!wr_addr && !step) |=> $stable(idx));
endmodule

// File: rtl/tap_side_fx.sv
module tap_side_fx
   import tap_pkg::*;
#(
   parameter int IVT_AW = 3,
   parameter int WIN_AW = 4
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                ivt_we,
   input  logic                win_we,
   input  logic [IVT_AW-1:0]   ivt_idx,
   input  logic [WIN_AW-1:0]   win_idx,
   input  logic [SRV_W-3:0]    srv_hi,
   input  logic [PRI_W-1:0]    pri,
   output logic                win_evt_valid,
   output logic [WIN_AW-1:0]   win_evt_index,
   output logic                ivt_evt_valid,
   output logic [IVT_AW-1:0]   ivt_evt_index,
   output logic [SRV_W-3:0]    ivt_evt_server,
   output logic [PRI_W-1:0]    ivt_evt_prio
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         win_evt_valid  <= 1'b0;
         win_evt_index  <= '0;
         ivt_evt_valid  <= 1'b0;
         ivt_evt_index  <= '0;
         ivt_evt_server <= '0;
         ivt_evt_prio   <= '0;
      end else begin
         win_evt_valid <= win_we;
         ivt_evt_valid <= ivt_we;
         if (win_we) win_evt_index <= win_idx;
         if (ivt_we) begin
            ivt_evt_index  <= ivt_idx;
            ivt_evt_server <= srv_hi;
            ivt_evt_prio   <= pri;
         end
      end
   end

   // R10: a window strobe always follows a window write
   p_win_cause_r10: assert property (@(posedge clk) disable iff (!rst_n)
      win_evt_valid |-> $past(win_we));

   // R9: an interrupt-vector strobe always follows an interrupt-vector write
   p_ivt_cause_r9: assert property (@(posedge clk) disable iff (!rst_n)
      ivt_evt_valid |-> $past(ivt_we));
endmodule

// File: rtl/tap_port.sv
module tap_port
   import tap_pkg::*;
#(
   parameter int IDX_W      = 8,
   parameter int IVT_DEPTH  = 8,
   parameter int WIN_DEPTH  = 16,
   parameter int PE_NUM     = 4,
   parameter int STUB_DEPTH = 32
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic                         acc_valid,
   input  logic                         acc_write,
   input  logic                         acc_is_data,
   input  logic [DW-1:0]                acc_wdata,
   output logic [DW-1:0]                acc_rdata,
   output logic                         tbl_err,
   output logic                         win_evt_valid,
   output logic [$clog2(WIN_DEPTH)-1:0] win_evt_index,
   output logic                         ivt_evt_valid,
   output logic [$clog2(IVT_DEPTH)-1:0] ivt_evt_index,
   output logic [SRV_W-3:0]             ivt_evt_server,
   output logic [PRI_W-1:0]             ivt_evt_prio
);
   localparam int TVT_DEPTH = 2 * PE_NUM;
   localparam int PEV_DEPTH = PE_NUM;
   localparam int IVT_AW    = $clog2(IVT_DEPTH);
   localparam int WIN_AW    = $clog2(WIN_DEPTH);

   function automatic int depth_of(int t);
      case (t)
         0:       return IVT_DEPTH;
         1:       return WIN_DEPTH;
         2:       return TVT_DEPTH;
         3:       return PEV_DEPTH;
         default: return STUB_DEPTH;
      endcase
   endfunction

   // elaboration-time parameter checks
   if (!is_pow2(IVT_DEPTH) || !is_pow2(WIN_DEPTH) || !is_pow2(PE_NUM) ||
       !is_pow2(STUB_DEPTH)) begin : g_bad_depth
      $error("tap_port: every table depth must be a power of two above one");
   end
   if (IDX_W > SEL_LSB || (1 << IDX_W) < STUB_DEPTH || (1 << IDX_W) < WIN_DEPTH ||
       (1 << IDX_W) < TVT_DEPTH || (1 << IDX_W) < IVT_DEPTH) begin : g_bad_idx
      $error("tap_port: index field too narrow or overlaps the select field");
   end

   logic [IDX_W-1:0] idx, mask, eidx;
   logic [SEL_W-1:0] sel;
   logic             ainc;
   logic [DW-1:0]    addr_word;
   logic             tbl_ok, stored, data_acc, data_wr;
   logic [DW-1:0]    tbl_rd [NUM_STORED];

   always_comb begin
      case (sel)
         T_IVT:   mask = IDX_W'(IVT_DEPTH - 1);
         T_WIN:   mask = IDX_W'(WIN_DEPTH - 1);
         T_TVT:   mask = IDX_W'(TVT_DEPTH - 1);
         T_PEV:   mask = IDX_W'(PEV_DEPTH - 1);
         T_STUB:  mask = IDX_W'(STUB_DEPTH - 1);
         default: mask = '0;
      endcase
   end

   assign tbl_ok   = (sel <= T_STUB);
   assign stored   = (sel < T_STUB);
   assign eidx     = idx & mask;
   assign data_acc = acc_valid & acc_is_data;
   assign data_wr  = data_acc & acc_write;

   tap_addr_ctl #(.IDX_W(IDX_W)) u_addr (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_addr   (acc_valid & acc_write & ~acc_is_data),
      .wdata     (acc_wdata),
      .data_acc  (data_acc),
      .tbl_ok    (tbl_ok),
      .mask      (mask),
      .idx       (idx),
      .sel       (sel),
      .ainc      (ainc),
      .addr_word (addr_word)
   );

   for (genvar t = 0; t < NUM_STORED; t++) begin : g_tbl
      localparam int D  = depth_of(t);
      localparam int AW = $clog2(D);
      localparam logic [DW-1:0] KEEP = (t == 0) ? IVT_KEEP : '1;
      tap_table_ram #(.DEPTH(D), .KEEP(KEEP)) u_ram (
         .clk   (clk),
         .rst_n (rst_n),
         .we    (data_wr && (sel == SEL_W'(t))),
         .idx   (eidx[AW-1:0]),
         .wdata (acc_wdata),
         .rdata (tbl_rd[t])
      );
   end

   always_comb begin
      acc_rdata = '0;
      if (acc_valid && !acc_write) begin
         if (!acc_is_data)  acc_rdata = addr_word;
         else if (stored)   acc_rdata = tbl_rd[sel[1:0]];
      end
   end

   assign tbl_err = data_acc & ~tbl_ok;

   tap_side_fx #(.IVT_AW(IVT_AW), .WIN_AW(WIN_AW)) u_fx (
      .clk            (clk),
      .rst_n          (rst_n),
      .ivt_we         (data_wr && (sel == T_IVT)),
      .win_we         (data_wr && (sel == T_WIN)),
      .ivt_idx        (eidx[IVT_AW-1:0]),
      .win_idx        (eidx[WIN_AW-1:0]),
      .srv_hi         (acc_wdata[SRV_LSB+2 +: SRV_W-2]),
      .pri            (acc_wdata[PRI_LSB +: PRI_W]),
      .win_evt_valid  (win_evt_valid),
      .win_evt_index  (win_evt_index),
      .ivt_evt_valid  (ivt_evt_valid),
      .ivt_evt_index  (ivt_evt_index),
      .ivt_evt_server (ivt_evt_server),
      .ivt_evt_prio   (ivt_evt_prio)
   );

   // R7: an invalid-select access never returns data
   p_bad_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
      tbl_err |-> (acc_rdata == '0));
endmodule

// File: tb/tb_tap_port.sv
module tb_tap_port;
   logic        clk = 1'b0;
   logic        rst_n;
   logic        acc_valid, acc_write, acc_is_data;
   logic [63:0] acc_wdata, acc_rdata;
   logic        tbl_err, win_evt_valid, ivt_evt_valid;
   logic [3:0]  win_evt_index;
   logic [2:0]  ivt_evt_index;
   logic [13:0] ivt_evt_server;
   logic [7:0]  ivt_evt_prio;

   always #10 clk = ~clk;

   tap_port dut (
      .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_write(acc_write),
      .acc_is_data(acc_is_data), .acc_wdata(acc_wdata), .acc_rdata(acc_rdata),
      .tbl_err(tbl_err), .win_evt_valid(win_evt_valid), .win_evt_index(win_evt_index),
      .ivt_evt_valid(ivt_evt_valid), .ivt_evt_index(ivt_evt_index),
      .ivt_evt_server(ivt_evt_server), .ivt_evt_prio(ivt_evt_prio)
   );

   int total = 0;
   int fails = 0;
   string cur_tag = "R1";

   // reference model state
   logic [63:0] m_tbl [4][32];
   int  m_idx = 0, m_sel = 0;
   bit  m_ainc = 0;
   bit  e_wv = 0, e_iv = 0;
   int  e_wi = 0, e_ii = 0, e_is = 0, e_ip = 0;
   localparam logic [63:0] KEEP = 64'h000F_00FF_FF00_FF00;

   function automatic int mmask(int s);
      case (s)
         0: return 7;
         1: return 15;
         2: return 7;
         3: return 3;
         4: return 31;
         default: return 0;
      endcase
   endfunction

   function automatic logic [63:0] addr(int s, int i, bit a);
      return (64'(a) << 31) | (64'(s & 15) << 16) | 64'(i & 255);
   endfunction

   function automatic logic [63:0] pat(int t, int i);
      return (64'hC3A5_0F1E_5A69_7788 ^ (64'(i + 1) * 64'h0101_0203_0405_0607)) + 64'(t << 40);
   endfunction

   task automatic check(string tag, string what, logic [63:0] act, logic [63:0] exp);
      total++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
      end
   endtask

   task automatic op(bit v, bit w, bit d, logic [63:0] wd);
      logic [63:0] exp_rd;
      bit exp_err;
      bit n_wv, n_iv;
      int n_wi, n_ii, n_is, n_ip, ei;
      @(negedge clk);
      acc_valid = v; acc_write = w; acc_is_data = d; acc_wdata = wd;
      #5;
      exp_rd = '0; exp_err = 0;
      ei = m_idx & mmask(m_sel);
      if (v && !w && !d) exp_rd = addr(m_sel, m_idx, m_ainc);
      if (v && !w && d && m_sel < 4) exp_rd = m_tbl[m_sel][ei];
      if (v && d && m_sel > 4) exp_err = 1;
      check(cur_tag, "rdata", acc_rdata, exp_rd);
      check("R7", "tbl_err", 64'(tbl_err), 64'(exp_err));
      check("R10", "win_evt_valid", 64'(win_evt_valid), 64'(e_wv));
      if (e_wv) check("R10", "win_evt_index", 64'(win_evt_index), 64'(e_wi));
      check("R9", "ivt_evt_valid", 64'(ivt_evt_valid), 64'(e_iv));
      if (e_iv) begin
         check("R9", "ivt_evt_index", 64'(ivt_evt_index), 64'(e_ii));
         check("R9", "ivt_evt_server", 64'(ivt_evt_server), 64'(e_is));
         check("R9", "ivt_evt_prio", 64'(ivt_evt_prio), 64'(e_ip));
      end
      n_wv = 0; n_iv = 0; n_wi = 0; n_ii = 0; n_is = 0; n_ip = 0;
      if (v && d) begin
         if (m_sel <= 4) begin
            if (w && m_sel < 4) m_tbl[m_sel][ei] = (m_sel == 0) ? (wd & KEEP) : wd;
            if (w && m_sel == 0) begin
               n_iv = 1; n_ii = ei;
               n_is = int'((wd >> 26) & 64'h3FFF);
               n_ip = int'((wd >> 8) & 64'hFF);
            end
            if (w && m_sel == 1) begin n_wv = 1; n_wi = ei; end
            if (m_ainc) m_idx = (m_idx + 1) & mmask(m_sel);
         end
      end else if (v && w) begin
         m_idx = int'(wd[7:0]); m_sel = int'(wd[19:16]); m_ainc = wd[31];
      end
      e_wv = n_wv; e_wi = n_wi; e_iv = n_iv; e_ii = n_ii; e_is = n_is; e_ip = n_ip;
   endtask

   task automatic set_addr(int s, int i, bit a);
      op(1, 1, 0, addr(s, i, a));
   endtask

   task automatic rd_addr();
      op(1, 0, 0, '0);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      fails++; total++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
   end

   initial begin
      for (int t = 0; t < 4; t++) for (int i = 0; i < 32; i++) m_tbl[t][i] = '0;
      rst_n = 0; acc_valid = 0; acc_write = 0; acc_is_data = 0; acc_wdata = '0;
      repeat (3) @(posedge clk);
      @(negedge clk) rst_n = 1;

      // R1: reset state, every stored entry reads zero
      cur_tag = "R1";
      rd_addr();
      for (int t = 0; t < 4; t++) begin
         set_addr(t, 0, 1);
         for (int i = 0; i <= mmask(t); i++) op(1, 0, 1, '0);
      end

      // R2: address register field keeping and read-back
      cur_tag = "R2";
      set_addr(0, 0, 0);
      op(1, 1, 0, 64'hFFFF_FFFF_FFFF_FFFF); rd_addr();
      op(1, 1, 0, 64'h1234_5678_9ABC_DEF0); rd_addr();

      // R4: fill the full-width tables; R10 strobes on window writes
      cur_tag = "R4";
      for (int t = 1; t < 4; t++) begin
         set_addr(t, 0, 1);
         for (int i = 0; i <= mmask(t); i++) op(1, 1, 1, pat(t, i));
      end
      // R6: read back each table over its own depth
      cur_tag = "R6";
      for (int t = 1; t < 4; t++) begin
         set_addr(t, 0, 1);
         for (int i = 0; i <= mmask(t) + 2; i++) op(1, 0, 1, '0);
         rd_addr();
      end

      // R5: stepping, holding and wrap that clears high index bits
      cur_tag = "R5";
      set_addr(1, 8'h25, 0);
      op(1, 0, 1, '0); op(1, 0, 1, '0); rd_addr();
      set_addr(1, 8'h25, 1);
      op(1, 0, 1, '0); rd_addr(); op(1, 0, 1, '0);
      set_addr(2, 7, 1); op(1, 0, 1, '0); rd_addr();
      set_addr(3, 8'hFF, 1); op(1, 1, 1, 64'hDEAD_BEEF_0000_0001); rd_addr();

      // R8 / R9: sanitised interrupt-vector writes and their strobes
      cur_tag = "R8";
      set_addr(0, 8'h0F, 1);
      op(1, 1, 1, 64'hFFFF_FFFF_FFFF_FFFF);
      op(1, 1, 1, 64'h0123_4567_89AB_CDEF);
      op(1, 1, 1, 64'h0005_00C3_0000_4100);
      op(0, 0, 0, '0);
      set_addr(0, 0, 1);
      for (int i = 0; i < 8; i++) op(1, 0, 1, '0);
      cur_tag = "R9";
      set_addr(0, 3, 0);
      op(1, 1, 1, 64'h0000_00FF_FC00_AB00);
      op(1, 1, 1, 64'h0000_0012_3400_0700);
      op(1, 0, 1, '0);

      // R6: stub select reads zero, ignores writes, steps and wraps at 32
      cur_tag = "R6";
      set_addr(4, 0, 1);
      for (int i = 0; i < 33; i++) op(1, (i % 2) == 0, 1, pat(4, i));
      rd_addr();

      // R7: invalid selects flag, read zero, do not step or store
      cur_tag = "R7";
      set_addr(9, 3, 1);
      op(1, 0, 1, '0); op(1, 1, 1, 64'h5555_AAAA_5555_AAAA); rd_addr();
      set_addr(15, 1, 1); op(1, 1, 1, '1); op(1, 0, 1, '0); rd_addr();
      set_addr(1, 3, 0); op(1, 0, 1, '0);

      // R3: no read means zero data; read in the same cycle
      cur_tag = "R3";
      op(0, 0, 1, '0); op(0, 1, 0, '1);
      set_addr(2, 5, 0);
      op(1, 1, 1, 64'h0F0F_0F0F_F0F0_F0F0);
      op(1, 0, 1, '0);
      op(1, 1, 0, addr(3, 2, 0));
      op(1, 0, 1, '0);

      // R10: only window writes strobe; a final window write
      cur_tag = "R10";
      set_addr(1, 14, 1);
      op(1, 1, 1, 64'h1111_2222_3333_4444);
      op(1, 1, 1, 64'h5555_6666_7777_8888);
      op(1, 0, 1, '0);
      set_addr(1, 14, 0); op(1, 0, 1, '0);
      op(0, 0, 0, '0); op(0, 0, 0, '0);

      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
   end
endmodule